// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block produces the converter clock and the cycle-by-cycle schedule of a single successive-approximation conversion. One of four clock sources is picked and then divided by a power of two. The divided clock, called the converter clock here, paces two phases: a sample phase whose length is programmable, then one bit-decision step per result bit. The analog comparator is modelled by a digital input word. At the end of the sample phase that word is held, and the bits are then resolved one at a time from the most significant down.

Software or a trigger source sends a single-cycle start pulse. The block raises a busy flag and, when the conversion ends, emits a one-cycle done pulse and updates the result. In continuous mode each finished conversion is followed at once by the next, and busy stays high between them.

Top module: `sar_timing_seq`

## Requirements
- R1: The clock-source code `src_sel` picks the event that advances the divider. 0 is every system-clock cycle. 1 is every second system-clock cycle. 2 is each cycle in which `alt_tick` is high. 3 is each rising edge of `async_clk`, taken after a two-stage synchronizer.
- R2: The divider code `div_sel` 0..3 makes one converter-clock tick from every 1, 2, 4 or 8 source events.
- R3: With `long_smp` low, the sample-period code `smp_sel` 0..3 gives a sample phase of 2, 4, 6 or 8 converter clocks.
- R4: With `long_smp` high, the same code gives 12, 16, 20 or 24 converter clocks.
- R5: The bit phase takes one converter clock per result bit. The resolution code `res_sel` gives 0 = 8 bits, 1 = 10 bits, and 2 or 3 = 12 bits. From bus source with divide-by-1, `done` is high in the cycle after the clock edge that is (sample + bits) edges after the edge that accepted `start`.
- R6: `result` is right-justified and equals `ain` masked to the selected resolution. It changes only in the cycle where `done` is high, and it resets to 0.
- R7: `ain` is held at the last sample tick. Changes on `ain` during the bit phase do not affect the result.
- R8: `busy` is high from the cycle after start acceptance through the last bit decision. `done` is a one-cycle pulse. With continuous mode off, `busy` is low in the cycle where `done` is high.
- R9: With `cont_en` high, a new conversion starts at the done edge with no gap. `busy` stays high and done pulses repeat at a fixed period. Clearing `cont_en` stops the sequence after the current conversion.
- R10: A `start` pulse while `busy` is high is ignored, and conversion timing is unchanged.
- R11: Any change of `src_sel` or `div_sel` restarts the divider count at zero, and no converter tick is produced in the cycle the change is seen. Accepting `start` also restarts it.
- R12: After reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Clock-source code |
| div_sel | input | 2 | Converter-clock divider code |
| smp_sel | input | 2 | Sample-period code |
| long_smp | input | 1 | Selects the long sample-time table |
| res_sel | input | 2 | Resolution code |
| cont_en | input | 1 | Continuous conversion enable |
| start | input | 1 | Start pulse |
| alt_tick | input | 1 | Alternate-clock event strobe |
| async_clk | input | 1 | Asynchronous clock level |
| ain | input | 12 | Digital stand-in for the analog input |
| busy | output | 1 | Conversion active |
| result | output | 12 | Right-justified conversion result |
| done | output | 1 | One-cycle conversion-complete pulse |

## Verification
The hardest case to reach is a divider restart in the middle of a conversion. The divider code has to change at a known point between two converter ticks, while the count is neither zero nor at its wrap value. The bench starts a conversion with divide-by-4 and switches to divide-by-2 on a counted cycle in the sample phase. It then checks that `done` arrives two cycles later than it would if the count had continued. The bench uses the same counted-cycle injection to change `ain` after it has been held and to send a second start pulse during a conversion.

// File: rtl/sar_timing_seq_pkg.sv
package sar_timing_seq_pkg;

  localparam int DATA_W  = 12;
  localparam int SMP_W   = 5;
  localparam int BIT_W   = 4;
  localparam int DIV_W   = 3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_t;

  // Sample phase length in converter clocks.
  function automatic logic [SMP_W-1:0] smp_len(input logic [1:0] code, input logic long_mode);
    logic [SMP_W-1:0] base;
    logic [SMP_W-1:0] step;
    base = long_mode ? SMP_W'(12) : SMP_W'(2);
    step = long_mode ? SMP_W'(4) : SMP_W'(2);
    return base + step * SMP_W'(code);
  endfunction

  // Number of result bits for a resolution code.
  function automatic logic [BIT_W-1:0] res_bits(input logic [1:0] code);
    case (code)
      2'd0:    return BIT_W'(8);
      2'd1:    return BIT_W'(10);
      default: return BIT_W'(12);
    endcase
  endfunction

  // Divide ratio minus one, so the divider wraps at this count.
  function automatic logic [DIV_W-1:0] div_last(input logic [1:0] code);
    return DIV_W'((4'd1 << code) - 4'd1);
  endfunction

  function automatic logic [DATA_W-1:0] res_mask(input logic [BIT_W-1:0] nbits);
    return DATA_W'((32'd1 << nbits) - 32'd1);
  endfunction

endpackage

// File: rtl/sar_timing_seq_clkgen.sv
module sar_timing_seq_clkgen
  import sar_timing_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic [1:0] div_sel,
  input  logic       alt_tick,
  input  logic       async_clk,
  input  logic       start_acc,
  output logic       src_tick,
  output logic       conv_tick,
  output logic       restart
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [1:0]       src_q;
  logic [1:0]       div_q;
  logic             half_t;
  logic [SH_W-1:0]  as_sh;
  logic [DIV_W-1:0] dcnt;
  logic             as_tick;
  logic             wrap;

  // Synchronizer chain plus one extra stage for edge detection.
  genvar g;
  generate
    for (g = 0; g < SH_W; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) as_sh[0] <= 1'b0;
          else        as_sh[0] <= async_clk;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) as_sh[g] <= 1'b0;
          else        as_sh[g] <= as_sh[g-1];
      end
    end
  endgenerate

  assign as_tick = as_sh[SH_W-2] & ~as_sh[SH_W-1];

  always_comb begin
    case (src_sel)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = half_t;
      2'd2:    src_tick = alt_tick;
      default: src_tick = as_tick;
    endcase
  end

  assign restart   = start_acc || (src_sel != src_q) || (div_sel != div_q);
  assign wrap      = dcnt >= div_last(div_sel);
  assign conv_tick = src_tick && wrap && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 2'd0;
      div_q  <= 2'd0;
      half_t <= 1'b0;
      dcnt   <= '0;
    end else begin
      src_q <= src_sel;
      div_q <= div_sel;
      if (restart) begin
        half_t <= 1'b0;
        dcnt   <= '0;
      end else begin
        half_t <= ~half_t;
        if (src_tick) dcnt <= wrap ? '0 : dcnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/sar_timing_seq_ctrl.sv
module sar_timing_seq_ctrl
  import sar_timing_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_en,
  input  logic             conv_tick,
  input  logic [1:0]       smp_sel,
  input  logic             long_smp,
  input  logic [1:0]       res_sel,
  output phase_t           phase,
  output logic             start_acc,
  output logic             hold_en,
  output logic             bit_en,
  output logic             last_bit,
  output logic [BIT_W-1:0] bit_idx,
  output logic [BIT_W-1:0] nbits,
  output logic             done
);

  logic [SMP_W-1:0] smp_cnt;
  logic [SMP_W-1:0] smp_lim;

  assign start_acc = (phase == PH_IDLE) && start;
  assign hold_en   = (phase == PH_SAMPLE) && conv_tick && (smp_cnt == smp_lim - SMP_W'(1));
  assign bit_en    = (phase == PH_CONVERT) && conv_tick;
  assign last_bit  = bit_en && (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      smp_cnt <= '0;
      smp_lim <= '0;
      bit_idx <= '0;
      nbits   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        phase   <= PH_SAMPLE;
        smp_cnt <= '0;
        smp_lim <= smp_len(smp_sel, long_smp);
        nbits   <= res_bits(res_sel);
      end else if (hold_en) begin
        phase   <= PH_CONVERT;
        bit_idx <= nbits - BIT_W'(1);
      end else if ((phase == PH_SAMPLE) && conv_tick) begin
        smp_cnt <= smp_cnt + SMP_W'(1);
      end else if (last_bit) begin
        done <= 1'b1;
        if (cont_en) begin
          phase   <= PH_SAMPLE;
          smp_cnt <= '0;
          smp_lim <= smp_len(smp_sel, long_smp);
          nbits   <= res_bits(res_sel);
        end else begin
          phase <= PH_IDLE;
        end
      end else if (bit_en) begin
        bit_idx <= bit_idx - BIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sar_timing_seq_sar.sv
module sar_timing_seq_sar
  import sar_timing_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ain,
  input  logic [BIT_W-1:0]  nbits,
  input  logic              hold_en,
  input  logic              bit_en,
  input  logic              last_bit,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] sar;
  logic [DATA_W-1:0] trial;
  logic [DATA_W-1:0] sar_nxt;

  assign trial   = sar | (DATA_W'(1) << bit_idx);
  assign sar_nxt = (trial <= held) ? trial : sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      sar    <= '0;
      result <= '0;
    end else begin
      if (hold_en) begin
        held <= ain & res_mask(nbits);
        sar  <= '0;
      end else if (bit_en) begin
        sar <= sar_nxt;
      end
      if (last_bit) result <= sar_nxt;
    end
  end

endmodule

// File: rtl/sar_timing_seq.sv
module sar_timing_seq
  import sar_timing_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  src_sel,
  input  logic [1:0]  div_sel,
  input  logic [1:0]  smp_sel,
  input  logic        long_smp,
  input  logic [1:0]  res_sel,
  input  logic        cont_en,
  input  logic        start,
  input  logic        alt_tick,
  input  logic        async_clk,
  input  logic [11:0] ain,
  output logic        busy,
  output logic [11:0] result,
  output logic        done
);

  logic             src_tick;
  logic             conv_tick;
  logic             restart;
  logic             start_acc;
  logic             hold_en;
  logic             bit_en;
  logic             last_bit;
  logic [BIT_W-1:0] bit_idx;
  logic [BIT_W-1:0] nbits;
  phase_t           phase;

  sar_timing_seq_clkgen #(.SYNC_STAGES(2)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .div_sel   (div_sel),
    .alt_tick  (alt_tick),
    .async_clk (async_clk),
    .start_acc (start_acc),
    .src_tick  (src_tick),
    .conv_tick (conv_tick),
    .restart   (restart)
  );

  sar_timing_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cont_en   (cont_en),
    .conv_tick (conv_tick),
    .smp_sel   (smp_sel),
    .long_smp  (long_smp),
    .res_sel   (res_sel),
    .phase     (phase),
    .start_acc (start_acc),
    .hold_en   (hold_en),
    .bit_en    (bit_en),
    .last_bit  (last_bit),
    .bit_idx   (bit_idx),
    .nbits     (nbits),
    .done      (done)
  );

  sar_timing_seq_sar u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .ain      (ain),
    .nbits    (nbits),
    .hold_en  (hold_en),
    .bit_en   (bit_en),
    .last_bit (last_bit),
    .bit_idx  (bit_idx),
    .result   (result)
  );

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/sar_timing_seq_chk.sv
module sar_timing_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cont_en,
  input logic        busy,
  input logic        done,
  input logic [11:0] result,
  input logic        src_tick,
  input logic        conv_tick,
  input logic        restart,
  input logic        bit_en,
  input logic [1:0]  phase
);

  a_r1_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |-> src_tick);

  a_r11_restart_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !conv_tick);

  a_r5_bits_only_in_convert: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> (phase == 2'd2));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cont_en)) |-> !busy);

  a_r9_cont_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cont_en)) |-> busy);

  a_r6_result_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !conv_tick) |=> $stable(phase));

endmodule

bind sar_timing_seq sar_timing_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cont_en   (cont_en),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .src_tick  (src_tick),
  .conv_tick (conv_tick),
  .restart   (restart),
  .bit_en    (bit_en),
  .phase     (phase)
);

// File: tb/test_sar_timing_seq.sv
`timescale 1ns/1ps
module test_sar_timing_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [1:0]  div_sel = 2'd0;
  logic [1:0]  smp_sel = 2'd0;
  logic        long_smp = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        cont_en = 1'b0;
  logic        start = 1'b0;
  logic        alt_tick = 1'b0;
  logic        async_clk = 1'b0;
  logic [11:0] ain = 12'd0;
  logic        busy;
  logic [11:0] result;
  logic        done;

  int errors = 0;
  int checks = 0;

  // Injection points, counted in edges after the start edge; -1 = unused.
  int          inj_start_k = -1;
  int          ain_chg_k   = -1;
  logic [11:0] ain_new     = 12'd0;
  int          div_chg_k   = -1;
  logic [1:0]  div_new     = 2'd0;
  bit          alt_gen     = 1'b0;
  bit          async_gen   = 1'b0;

  always #2 clk = ~clk;

  sar_timing_seq i_sar_timing_seq (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
    .smp_sel(smp_sel), .long_smp(long_smp), .res_sel(res_sel),
    .cont_en(cont_en), .start(start), .alt_tick(alt_tick),
    .async_clk(async_clk), .ain(ain), .busy(busy), .result(result),
    .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] sc, input logic lg, input logic [1:0] rc);
    int s;
    int b;
    s = lg ? (12 + 4 * int'(sc)) : (2 + 2 * int'(sc));
    b = (rc == 2'd0) ? 8 : ((rc == 2'd1) ? 10 : 12);
    return s + b;
  endfunction

  function automatic logic [11:0] exp_res(input logic [11:0] a, input logic [1:0] rc);
    if (rc == 2'd0) return a & 12'h0FF;
    if (rc == 2'd1) return a & 12'h3FF;
    return a;
  endfunction

  // Starts one conversion and counts edges until done; busy_gap counts busy-low samples before done.
  task automatic run_conv(output int k, output logic [11:0] r, output int busy_gap, output int busy_after);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0; busy_gap = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!done && !busy) busy_gap++;
      if (done) break;
      start = ((k + 1) == inj_start_k);
      if ((k + 1) == ain_chg_k) ain = ain_new;
      if ((k + 1) == div_chg_k) div_sel = div_new;
      alt_tick  = alt_gen && (((k + 1) % 3) == 0);
      if (async_gen) async_clk = (((k + 1) / 4) % 2) == 1;
      @(negedge clk);
      k++;
    end
    start = 1'b0; alt_tick = 1'b0;
    r = result;
    busy_after = int'(busy);
    inj_start_k = -1; ain_chg_k = -1; div_chg_k = -1;
    alt_gen = 1'b0; async_gen = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 busy after reset", int'(busy), 0);
    check("R12 done after reset", int'(done), 0);
    check("R12 result after reset", int'(result), 0);
  endtask

  task automatic t_bus_8bit;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd0; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'hF5A;
    run_conv(k, r, gap, ba);
    check("R5 bus div1 length", k, exp_len(2'd0, 1'b0, 2'd0));
    check("R6 8-bit masked result", int'(r), int'(exp_res(12'hF5A, 2'd0)));
    check("R8 busy through conversion", gap, 0);
    check("R8 busy low at done", ba, 0);
  endtask

  task automatic t_half_10bit;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd1; div_sel = 2'd1; smp_sel = 2'd1; long_smp = 1'b0; res_sel = 2'd1;
    ain = 12'hEC7;
    run_conv(k, r, gap, ba);
    check("R1 R2 R3 half-bus div2 length", k, exp_len(2'd1, 1'b0, 2'd1) * 2 * 2);
    check("R6 10-bit result", int'(r), int'(exp_res(12'hEC7, 2'd1)));
  endtask

  task automatic t_div8;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd3; smp_sel = 2'd3; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h013;
    run_conv(k, r, gap, ba);
    check("R2 R3 div8 short code3 length", k, exp_len(2'd3, 1'b0, 2'd0) * 8);
    check("R6 small value", int'(r), 16'h13);
  endtask

  task automatic t_long_12bit;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd0; smp_sel = 2'd3; long_smp = 1'b1; res_sel = 2'd2;
    ain = 12'hABC;
    run_conv(k, r, gap, ba);
    check("R4 long code3 length", k, 36);
    check("R6 12-bit result", int'(r), 16'hABC);
    smp_sel = 2'd0; res_sel = 2'd3; ain = 12'hFFF;
    run_conv(k, r, gap, ba);
    check("R4 R5 long code0 code3-res length", k, exp_len(2'd0, 1'b1, 2'd3));
    check("R5 res code 3 is 12 bits", int'(r), 16'hFFF);
  endtask

  task automatic t_alt;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd2; div_sel = 2'd0; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h080; alt_gen = 1'b1;
    run_conv(k, r, gap, ba);
    check("R1 alternate strobe length", k, 30);
    check("R6 alternate result", int'(r), 16'h80);
  endtask

  task automatic t_async;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd3; div_sel = 2'd0; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h0C3; async_gen = 1'b1;
    run_conv(k, r, gap, ba);
    check("R1 async source paced", int'(k >= 72 && k <= 88), 1);
    check("R6 async result", int'(r), 16'hC3);
    async_clk = 1'b0;
  endtask

  task automatic t_ain_hold;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd0; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h05A; ain_chg_k = 4; ain_new = 12'h0A5;
    run_conv(k, r, gap, ba);
    check("R7 ain change after hold ignored", int'(r), 16'h5A);
  endtask

  task automatic t_start_ignored;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd0; smp_sel = 2'd1; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h033; inj_start_k = 6;
    run_conv(k, r, gap, ba);
    check("R10 start while busy leaves length", k, exp_len(2'd1, 1'b0, 2'd0));
    check("R10 result intact", int'(r), 16'h33);
  endtask

  task automatic t_restart;
    int k; logic [11:0] r; int gap; int ba;
    src_sel = 2'd0; div_sel = 2'd2; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h0F0; div_chg_k = 6; div_new = 2'd1;
    run_conv(k, r, gap, ba);
    check("R11 divider restart on code change", k, 24);
  endtask

  task automatic t_cont;
    int k; int nd; int gap; int t1; int t2; int t3; int busy_end;
    src_sel = 2'd0; div_sel = 2'd0; smp_sel = 2'd0; long_smp = 1'b0; res_sel = 2'd0;
    ain = 12'h077; cont_en = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0; nd = 0; gap = 0; t1 = 0; t2 = 0; t3 = 0; busy_end = 1;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        nd++;
        if (nd == 1) t1 = k;
        if (nd == 2) t2 = k;
        if (nd == 3) begin t3 = k; cont_en = 1'b0; end
        if (nd == 4) begin busy_end = int'(busy); break; end
      end else if (!busy) gap++;
      @(negedge clk);
      k++;
    end
    check("R9 first continuous done", t1, 10);
    check("R9 continuous period", t2 - t1, 10);
    check("R9 third continuous done", t3, 30);
    check("R9 busy held between conversions", gap, 0);
    check("R9 stop after clearing enable", busy_end, 0);
    check("R9 continuous result", int'(result), 16'h77);
    repeat (20) @(negedge clk);
    check("R9 no further conversion", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_8bit();
    t_half_10bit();
    t_div8();
    t_long_12bit();
    t_alt();
    t_async();
    t_ain_hold();
    t_start_ignored();
    t_restart();
    t_cont();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule